// File: doc/BRIEF.md
# Find-First-One Execution Unit

This block executes one instruction: a scan of a 32-bit data register for its most significant set bit. Each cycle it takes a 16-bit instruction word with a valid strobe. When the word carries the find-first-one opcode, the unit does the following in one clock edge:

- reads the data register named by the word's low three bits;
- counts how far the first 1 lies below bit 31;
- writes that count back into the same register;
- updates a five-bit condition code register.

Any other word changes no state. So does a cycle with the valid strobe low.

The block holds an eight-entry data register file and the condition code register. A preset port loads a register before an instruction is issued. A combinational read port shows any register so its contents can be observed. The write-back bus is exposed on the ports, so a surrounding core or a bench can watch what the unit is about to commit.

Top module: `ff1_unit`

## Requirements
- R1: The result is the number of bit positions between bit 31 and the most significant 1 of the source. A 1 in bit 31 gives 0, and a source whose only 1 is bit 0 gives 31.
- R2: A source of all zeros gives the result 32 (0x00000020).
- R3: The result is zero-extended to 32 bits. It is written into the same register that was read, which is the one selected by instruction bits 2..0.
- R4: An instruction is accepted only when `instr_valid_i` is 1 and bits 15..3 equal 13'b0000010011000. Any other word, or a low strobe, leaves every register and the condition code register unchanged.
- R5: Condition code bit 3 (N) becomes bit 31 of the source value.
- R6: Condition code bit 2 (Z) becomes 1 exactly when the source value is zero.
- R7: Condition code bits 1 (V) and 0 (C) are cleared by every accepted instruction.
- R8: Condition code bit 4 (X) keeps its previous value across an accepted instruction.
- R9: Register and flag updates take effect on the clock edge that samples an accepted instruction. The flags come from the value read before the write-back.
- R10: Reset (`rst_ni` low) clears all eight registers and the condition code register.
- R11: `load_en_i` writes `load_data_i` into register `load_idx_i` on the clock edge. If a load and a write-back target the same register in the same cycle, the load wins, but the flags still update.
- R12: `rd_data_o` combinationally shows register `rd_idx_i`, and `ccr_o` shows the condition code register. `wb_en_o`, `wb_idx_o` and `wb_data_o` show the pending write-back in the cycle the instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 16 | Instruction word |
| load_en_i | input | 1 | Register preset enable |
| load_idx_i | input | 3 | Register preset index |
| load_data_i | input | 32 | Register preset value |
| rd_idx_i | input | 3 | Observation read index |
| rd_data_o | output | 32 | Observation read data |
| ccr_o | output | 5 | Condition codes {X,N,Z,V,C} |
| wb_en_o | output | 1 | Write-back pending this cycle |
| wb_idx_o | output | 3 | Write-back register index |
| wb_data_o | output | 32 | Write-back value |

## Verification
A fault in the scan or the decode shows up on `wb_data_o` in the same cycle the word is presented. It shows up in the destination register, read through `rd_data_o`, one edge later. A flag fault shows up in `ccr_o` right after the accepting edge. A stale read, where flags are taken from the written result instead of the source, changes N and Z, because the result never has bit 31 set and is never zero for a zero source. A decode that accepts near-miss words corrupts a register that the following full sweep of the read port exposes.

// File: rtl/ff1_pkg.sv
`timescale 1ns/1ps
package ff1_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned INSTR_W  = 16;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned CNT_W    = $clog2(DATA_W) + 1;
  localparam int unsigned OPC_W    = INSTR_W - IDX_W;
  localparam logic [OPC_W-1:0] OPC_FF1 = 13'b0000010011000;

  // condition code bit positions
  localparam int unsigned CC_C = 0;
  localparam int unsigned CC_V = 1;
  localparam int unsigned CC_Z = 2;
  localparam int unsigned CC_N = 3;
  localparam int unsigned CC_X = 4;
  localparam int unsigned CC_W = 5;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/ff1_decode.sv
`timescale 1ns/1ps
module ff1_decode
  import ff1_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter int unsigned XW = IDX_W,
  parameter logic [IW-XW-1:0] OPC = OPC_FF1
) (
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output logic          hit_o,
  output logic [XW-1:0] idx_o
);
  localparam int unsigned OW = IW - XW;

  logic [OW-1:0] opc_field;

  assign opc_field = instr_i[IW-1:XW];
  assign hit_o     = valid_i && (opc_field == OPC);
  assign idx_o     = instr_i[XW-1:0];
endmodule

// File: rtl/ff1_scan.sv
`timescale 1ns/1ps
module ff1_scan #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o,
  output logic          msb_o
);
  logic [CW-1:0] cnt;

  // ascending walk: the last hit is the highest set bit
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (data_i[i]) cnt = CW'(int'(W) - 1 - i);
    end
  end

  assign cnt_o  = cnt;
  assign zero_o = ~|data_i;
  assign msb_o  = data_i[W-1];
endmodule

// File: rtl/ff1_regfile.sv
`timescale 1ns/1ps
module ff1_regfile #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned XW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wb_en_i,
  input  logic [XW-1:0] wb_idx_i,
  input  logic [W-1:0]  wb_data_i,
  input  logic          ld_en_i,
  input  logic [XW-1:0] ld_idx_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic [XW-1:0] rs_idx_i,
  output logic [W-1:0]  rs_data_o,
  input  logic [XW-1:0] obs_idx_i,
  output logic [W-1:0]  obs_data_o
);
  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < int'(N); g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (ld_en_i && ld_idx_i == XW'(g)) begin
        regs_q[g] <= ld_data_i;   // preset wins over write-back
      end else if (wb_en_i && wb_idx_i == XW'(g)) begin
        regs_q[g] <= wb_data_i;
      end
    end
  end

  assign rs_data_o  = regs_q[rs_idx_i];
  assign obs_data_o = regs_q[obs_idx_i];
endmodule

// File: rtl/ff1_ccr.sv
`timescale 1ns/1ps
module ff1_ccr
  import ff1_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            n_i,
  input  logic            z_i,
  output logic [CC_W-1:0] ccr_o
);
  logic [CC_W-1:0] ccr_q;
  logic [CC_W-1:0] ccr_d;

  always_comb begin
    ccr_d = ccr_q;
    if (upd_i) begin
      ccr_d[CC_N] = n_i;
      ccr_d[CC_Z] = z_i;
      ccr_d[CC_V] = 1'b0;
      ccr_d[CC_C] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= '0;
    else         ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;
endmodule

// File: rtl/ff1_unit.sv
`timescale 1ns/1ps
module ff1_unit
  import ff1_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               load_en_i,
  input  logic [IDX_W-1:0]   load_idx_i,
  input  logic [DATA_W-1:0]  load_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [CC_W-1:0]    ccr_o,
  output logic               wb_en_o,
  output logic [IDX_W-1:0]   wb_idx_o,
  output logic [DATA_W-1:0]  wb_data_o
);
  dec_t              dec;
  logic [DATA_W-1:0] src_data;
  logic [CNT_W-1:0]  cnt;
  logic              src_zero;
  logic              src_msb;

  ff1_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .hit_o   (dec.hit),
    .idx_o   (dec.idx)
  );

  ff1_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_en_i    (dec.hit),
    .wb_idx_i   (dec.idx),
    .wb_data_i  (wb_data_o),
    .ld_en_i    (load_en_i),
    .ld_idx_i   (load_idx_i),
    .ld_data_i  (load_data_i),
    .rs_idx_i   (dec.idx),
    .rs_data_o  (src_data),
    .obs_idx_i  (rd_idx_i),
    .obs_data_o (rd_data_o)
  );

  ff1_scan #(.W(DATA_W), .CW(CNT_W)) u_scan (
    .data_i (src_data),
    .cnt_o  (cnt),
    .zero_o (src_zero),
    .msb_o  (src_msb)
  );

  ff1_ccr u_ccr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (dec.hit),
    .n_i    (src_msb),
    .z_i    (src_zero),
    .ccr_o  (ccr_o)
  );

  assign wb_en_o   = dec.hit;
  assign wb_idx_o  = dec.idx;
  assign wb_data_o = {{(DATA_W-CNT_W){1'b0}}, cnt};
endmodule

// File: rtl/ff1_unit_chk.sv
`timescale 1ns/1ps
module ff1_unit_chk
  import ff1_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_en_i,
  input logic [CC_W-1:0]   ccr_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic [DATA_W-1:0] src_i
);
  // R1 / R2: result never exceeds the width
  a_r1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_data_o <= DATA_W);
  // R3: upper bits of the result stay clear
  a_r3_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_data_o[DATA_W-1:CNT_W] == '0);
  // R5
  a_r5_n_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> ccr_o[CC_N] == $past(src_i[DATA_W-1]));
  // R6
  a_r6_z_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> ccr_o[CC_Z] == ($past(src_i) == '0));
  // R7
  a_r7_vc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> ccr_o[CC_V:CC_C] == 2'b00);
  // R8
  a_r8_x_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> $stable(ccr_o[CC_X]));
  // R4
  a_r4_idle_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wb_en_o && !load_en_i) |=> $stable(ccr_o));
endmodule

bind ff1_unit ff1_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_i (load_en_i),
  .ccr_o     (ccr_o),
  .wb_en_o   (wb_en_o),
  .wb_data_o (wb_data_o),
  .src_i     (src_data)
);

// File: tb/tb_ff1_unit.sv
`timescale 1ns/1ps
module tb_ff1_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        load_en_i = 1'b0;
  logic [2:0]  load_idx_i = '0;
  logic [31:0] load_data_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic [4:0]  ccr_o;
  logic        wb_en_o;
  logic [2:0]  wb_idx_o;
  logic [31:0] wb_data_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [8];
  logic [4:0]  mccr;

  always #2.5 clk_i = ~clk_i;

  ff1_unit dut (.*);

  function automatic logic [31:0] exp_ff1(logic [31:0] v);
    for (int b = 31; b >= 0; b--) if (v[b]) return 32'(31 - b);
    return 32'd32;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int r = 0; r < 8; r++) begin
      rd_idx_i = 3'(r);
      #0.1;
      chk(req, rd_data_o, mdl[r]);
    end
    chk(req, 32'(ccr_o), 32'(mccr));
  endtask

  task automatic preset(int r, logic [31:0] v);
    @(negedge clk_i);
    load_en_i = 1'b1; load_idx_i = 3'(r); load_data_i = v;
    @(negedge clk_i);
    load_en_i = 1'b0;
    mdl[r] = v;
    rd_idx_i = 3'(r);
    #0.1;
    chk("R11", rd_data_o, v);
  endtask

  task automatic run_ff1(int r);
    logic [31:0] src;
    src = mdl[r];
    @(negedge clk_i);
    instr_valid_i = 1'b1; instr_i = {13'b0000010011000, 3'(r)};
    #0.1;
    chk("R12", {28'd0, wb_en_o, wb_idx_o}, {28'd0, 1'b1, 3'(r)});
    chk("R1", wb_data_o, exp_ff1(src));
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    mdl[r] = exp_ff1(src);
    mccr = {mccr[4], src[31], src == 32'd0, 2'b00};
    rd_idx_i = 3'(r);
    #0.1;
    chk("R3", rd_data_o, mdl[r]);
    chk("R5", 32'(ccr_o[3]), 32'(src[31]));
    chk("R6", 32'(ccr_o[2]), 32'(src == 32'd0));
    chk("R7", 32'(ccr_o[1:0]), 32'd0);
    chk("R8", 32'(ccr_o[4]), 32'(mccr[4]));
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    mccr = '0;
    repeat (3) @(negedge clk_i);
    sweep("R10");
    rst_ni = 1'b1;
    // directed corners
    preset(1, 32'h8000_0000); run_ff1(1);   // R1 msb -> 0
    preset(2, 32'h0000_0001); run_ff1(2);   // R1 lsb -> 31
    preset(3, 32'h0000_0000); run_ff1(3);   // R2 zero -> 32
    chk("R2", mdl[3], 32'h20);
    preset(4, 32'h0001_ffff); run_ff1(4);
    run_ff1(4);                              // R9 second pass on result
    // R11 same-cycle load and write-back to one register
    preset(5, 32'h0000_0100);
    @(negedge clk_i);
    instr_valid_i = 1'b1; instr_i = {13'b0000010011000, 3'd5};
    load_en_i = 1'b1; load_idx_i = 3'd5; load_data_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    instr_valid_i = 1'b0; load_en_i = 1'b0;
    mdl[5] = 32'hDEAD_BEEF; mccr = {mccr[4], 1'b0, 1'b0, 2'b00};
    sweep("R11");
    // R4 near-miss opcodes and low strobe
    for (int k = 0; k < 13; k++) begin
      @(negedge clk_i);
      instr_valid_i = 1'b1;
      instr_i = {13'b0000010011000 ^ (13'd1 << k), 3'(k)};
      @(negedge clk_i);
      instr_valid_i = 1'b0;
      sweep("R4");
    end
    @(negedge clk_i);
    instr_valid_i = 1'b0; instr_i = {13'b0000010011000, 3'd1};
    @(negedge clk_i);
    sweep("R4");
    // random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [31:0] v;
      r = int'($urandom_range(0, 7));
      v = $urandom() >> $urandom_range(0, 31);
      if ($urandom_range(0, 9) == 0) v = '0;
      preset(r, v);
      run_ff1(r);
      if ($urandom_range(0, 3) == 0) begin
        logic [15:0] w;
        w = 16'($urandom());
        if (w[15:3] == 13'b0000010011000) w[15] = 1'b1;
        @(negedge clk_i);
        instr_valid_i = 1'b1; instr_i = w;
        @(negedge clk_i);
        instr_valid_i = 1'b0;
        sweep("R4");
      end
    end
    sweep("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule